// File: doc/BRIEF.md
# Partitioned Vector Lane ALU

This block is one 64-bit lane of a vector coprocessor datapath. It treats each operand as a packed group of elements: one 64-bit element, two 32-bit elements, or four 16-bit elements. All the elements in a lane are processed in the same cycle. The operation code never carries the element width. A small width register, written through its own port, sets the width. The same add or subtract code therefore either joins the carry chain into one long word or cuts it at every element edge.

Each operation takes two packed sources, a per-element mask and the old destination value. It returns a packed result together with one flag bit per element. Add, subtract and bitwise logic write into the packed result. Equal and signed less-than compares produce flags only, meant for a one-bit-per-element flag register used later for masking or population count. The lane registers its output once, so the result arrives one clock after the operation is accepted.

Top module: `vec_lane_alu`

## Requirements
- R1: The width register selects the element layout. Code 2'b00 means one 64-bit element, 2'b01 means two 32-bit elements (element i in bits 32i+31:32i), and 2'b10 means four 16-bit elements (element i in bits 16i+15:16i). The reserved code 2'b11 behaves exactly like 2'b00.
- R2: Add (op 0) and subtract (op 1, a minus b) wrap modulo 2^width within each element. No carry or borrow crosses an element boundary at the selected width.
- R3: AND (op 2), OR (op 3) and XOR (op 4) act bitwise on the full 64 bits, and give the same result at every width.
- R4: Equal (op 5) and signed less-than (op 6, a < b) set flag bit i when element i satisfies the test. For compares, the data output returns the old destination value unchanged.
- R5: Flag bits at or above the active element count are zero. All flag bits are zero for any operation other than a compare.
- R6: Mask bit i governs element i, and 1 means write. A masked element returns its old destination bits, and its compare flag is 0. Mask bits at or above the element count are ignored.
- R7: An operation accepted with in_valid high at a rising edge shows its result and flags after that edge, with out_valid high for exactly that cycle. When in_valid is low, out_valid is low after the next edge.
- R8: A width written with cfg_we applies only to operations accepted on later edges. An operation accepted on the same edge as the write uses the previous width.
- R9: Synchronous active-high reset clears out_valid, out_data and out_flags, and returns the width register to 2'b00.
- R10: Op code 7 is reserved. It returns the old destination value and all-zero flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the element width register |
| cfg_width | input | 2 | New element width code |
| in_valid | input | 1 | Operation accepted at this edge |
| in_op | input | 3 | Operation code |
| in_mask | input | 4 | Per-element write mask |
| in_a | input | 64 | First packed source |
| in_b | input | 64 | Second packed source |
| in_old | input | 64 | Old destination value for masked elements |
| out_valid | output | 1 | Result valid |
| out_data | output | 64 | Packed result |
| out_flags | output | 4 | Per-element flag bits |

## Verification
The bench builds the lane with its default parameters: 16-bit segments, four segments per lane. With these, all three element layouts and the reserved width code can be reached, along with carries that sit exactly on a 16-bit or 32-bit seam. The vectors place all-ones fields next to element edges, so a carry or borrow that leaked across a seam would change a neighbouring field. They also use signed compares whose differences overflow. Directed steps cover a width write on the same edge as an operation, an idle cycle, and a reset in the middle of a run that must also restore the width.

// File: rtl/lane_pkg.sv
package lane_pkg;

  typedef enum logic [1:0] {
    WID_FULL    = 2'b00,
    WID_HALF    = 2'b01,
    WID_QUARTER = 2'b10,
    WID_RSVD    = 2'b11
  } lane_width_e;

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_AND = 3'd2,
    OP_OR  = 3'd3,
    OP_XOR = 3'd4,
    OP_CEQ = 3'd5,
    OP_CLT = 3'd6,
    OP_NOP = 3'd7
  } lane_op_e;

  // Reserved width code folds onto the full-width layout.
  function automatic lane_width_e norm_width(input logic [1:0] raw);
    if (raw == 2'b11) return WID_FULL;
    return lane_width_e'(raw);
  endfunction

  // Signed a < b from the sign bits of a, b and (a - b).
  function automatic logic signed_below(input logic a_msb, input logic b_msb,
                                        input logic d_msb);
    logic ovf;
    ovf = (a_msb ^ b_msb) & (a_msb ^ d_msb);
    return d_msb ^ ovf;
  endfunction

  function automatic logic op_writes(input lane_op_e op);
    return (op == OP_ADD) || (op == OP_SUB) || (op == OP_AND) ||
           (op == OP_OR)  || (op == OP_XOR);
  endfunction

  function automatic logic op_compares(input lane_op_e op);
    return (op == OP_CEQ) || (op == OP_CLT);
  endfunction

endpackage

// File: rtl/lane_seg_ctl.sv
import lane_pkg::*;

// Maps the element layout onto fixed-size segments: where each element
// starts, where it ends, and which mask bit owns each segment.
module lane_seg_ctl #(
  parameter int NSEG = 4
) (
  input  lane_width_e     width,
  input  logic [NSEG-1:0] elem_mask,
  output logic [NSEG-1:0] seg_first,
  output logic [NSEG-1:0] seg_last,
  output logic [NSEG-1:0] seg_mask
);
  localparam int HALF_RUN = NSEG / 2;

  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      case (width)
        WID_QUARTER: begin
          seg_first[s] = 1'b1;
          seg_last[s]  = 1'b1;
          seg_mask[s]  = elem_mask[s];
        end
        WID_HALF: begin
          seg_first[s] = (s % HALF_RUN) == 0;
          seg_last[s]  = (s % HALF_RUN) == (HALF_RUN - 1);
          seg_mask[s]  = elem_mask[s / HALF_RUN];
        end
        default: begin
          seg_first[s] = (s == 0);
          seg_last[s]  = (s == NSEG - 1);
          seg_mask[s]  = elem_mask[0];
        end
      endcase
    end
  end
endmodule

// File: rtl/lane_addsub.sv
// Segmented adder: the carry into a segment that starts an element is
// replaced by the subtract bit, so elements never exchange carries.
module lane_addsub #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int LANE_W = SEG_W * NSEG
) (
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic              sub,
  input  logic [NSEG-1:0]   seg_first,
  output logic [LANE_W-1:0] sum
);
  always_comb begin
    logic             carry;
    logic             cin;
    logic [SEG_W:0]   part;
    logic [SEG_W-1:0] bx;
    carry = sub;
    for (int s = 0; s < NSEG; s++) begin
      cin  = seg_first[s] ? sub : carry;
      bx   = b[s*SEG_W +: SEG_W] ^ {SEG_W{sub}};
      part = {1'b0, a[s*SEG_W +: SEG_W]} + {1'b0, bx} + {{SEG_W{1'b0}}, cin};
      sum[s*SEG_W +: SEG_W] = part[SEG_W-1:0];
      carry = part[SEG_W];
    end
  end
endmodule

// File: rtl/lane_cmp.sv
import lane_pkg::*;

// Per-element compare flags, packed so that element i lands in flag bit i.
module lane_cmp #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int LANE_W = SEG_W * NSEG
) (
  input  lane_width_e       width,
  input  logic              want_lt,
  input  logic [LANE_W-1:0] a,
  input  logic [LANE_W-1:0] b,
  input  logic [LANE_W-1:0] diff,
  input  logic [NSEG-1:0]   seg_first,
  input  logic [NSEG-1:0]   seg_last,
  input  logic [NSEG-1:0]   seg_mask,
  output logic [NSEG-1:0]   flags
);
  localparam int HALF_RUN = NSEG / 2;

  logic [NSEG-1:0] seg_res;

  always_comb begin
    logic run_eq;
    logic lt;
    run_eq = 1'b1;
    for (int s = 0; s < NSEG; s++) begin
      run_eq = (seg_first[s] | run_eq) &
               (a[s*SEG_W +: SEG_W] == b[s*SEG_W +: SEG_W]);
      lt = signed_below(a[s*SEG_W + SEG_W - 1], b[s*SEG_W + SEG_W - 1],
                        diff[s*SEG_W + SEG_W - 1]);
      seg_res[s] = (want_lt ? lt : run_eq) & seg_mask[s] & seg_last[s];
    end
  end

  always_comb begin
    flags = '0;
    case (width)
      WID_QUARTER: flags = seg_res;
      WID_HALF: begin
        for (int e = 0; e < 2; e++) flags[e] = seg_res[e*HALF_RUN + HALF_RUN - 1];
      end
      default: flags[0] = seg_res[NSEG-1];
    endcase
  end
endmodule

// File: rtl/vec_lane_alu.sv
import lane_pkg::*;

module vec_lane_alu #(
  parameter int SEG_W = 16,
  parameter int NSEG  = 4,
  localparam int LANE_W = SEG_W * NSEG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_width,
  input  logic              in_valid,
  input  logic [2:0]        in_op,
  input  logic [NSEG-1:0]   in_mask,
  input  logic [LANE_W-1:0] in_a,
  input  logic [LANE_W-1:0] in_b,
  input  logic [LANE_W-1:0] in_old,
  output logic              out_valid,
  output logic [LANE_W-1:0] out_data,
  output logic [NSEG-1:0]   out_flags
);
  // Width register: read by the operation accepted on the same edge
  // before the new code lands.
  logic [1:0] width_q;
  always_ff @(posedge clk) begin
    if (rst)         width_q <= 2'b00;
    else if (cfg_we) width_q <= cfg_width;
  end

  lane_width_e eff_width;
  lane_op_e    op_w;
  logic        sub_mode;
  logic        is_cmp;
  logic        is_write;
  assign eff_width = norm_width(width_q);
  assign op_w      = lane_op_e'(in_op);
  assign sub_mode  = (op_w == OP_SUB) || (op_w == OP_CLT);
  assign is_cmp    = op_compares(op_w);
  assign is_write  = op_writes(op_w);

  logic [NSEG-1:0] seg_first, seg_last, seg_mask;
  lane_seg_ctl #(.NSEG(NSEG)) u_ctl (
    .width(eff_width), .elem_mask(in_mask),
    .seg_first(seg_first), .seg_last(seg_last), .seg_mask(seg_mask)
  );

  logic [LANE_W-1:0] sum_w;
  lane_addsub #(.SEG_W(SEG_W), .NSEG(NSEG)) u_add (
    .a(in_a), .b(in_b), .sub(sub_mode), .seg_first(seg_first), .sum(sum_w)
  );

  logic [NSEG-1:0] cmp_flags;
  lane_cmp #(.SEG_W(SEG_W), .NSEG(NSEG)) u_cmp (
    .width(eff_width), .want_lt(op_w == OP_CLT),
    .a(in_a), .b(in_b), .diff(sum_w),
    .seg_first(seg_first), .seg_last(seg_last), .seg_mask(seg_mask),
    .flags(cmp_flags)
  );

  logic [LANE_W-1:0] alu_res;
  always_comb begin
    case (op_w)
      OP_AND:  alu_res = in_a & in_b;
      OP_OR:   alu_res = in_a | in_b;
      OP_XOR:  alu_res = in_a ^ in_b;
      default: alu_res = sum_w;
    endcase
  end

  // Named per-segment write events for the merge and the checks.
  logic [NSEG-1:0]   seg_take;
  logic [LANE_W-1:0] merged;
  logic [NSEG-1:0]   flags_next;
  always_comb begin
    for (int s = 0; s < NSEG; s++) begin
      seg_take[s] = is_write & seg_mask[s];
      merged[s*SEG_W +: SEG_W] = seg_take[s] ? alu_res[s*SEG_W +: SEG_W]
                                             : in_old[s*SEG_W +: SEG_W];
    end
    flags_next = is_cmp ? cmp_flags : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_flags <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_data  <= merged;
        out_flags <= flags_next;
      end
    end
  end

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_flags_nocmp_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_cmp) |=> (out_flags == '0));
  p_flags_half_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && eff_width == WID_HALF) |=> ((out_flags >> 2) == '0));
  p_flags_full_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && eff_width == WID_FULL) |=> ((out_flags >> 1) == '0));
  p_mask_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_mask[0]) |=> (out_data[SEG_W-1:0] == $past(in_old[SEG_W-1:0])));
  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0 && out_flags == '0));
endmodule

// File: tb/tb_vec_lane_alu.sv
module tb_vec_lane_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 22;

  typedef struct packed {
    logic [1:0]  w;
    logic [2:0]  op;
    logic [3:0]  mask;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] old;
    logic [63:0] exp;
    logic [3:0]  flg;
    logic [3:0]  req;
  } vec_t;

  // width, op, mask, a, b, old, expected data, expected flags, requirement
  localparam vec_t VECS [NVEC] = '{
    // R2: 16-bit seams stop carries
    '{2'd2, 3'd0, 4'hF, 64'h0001_FFFF_7FFF_0005, 64'h0001_0001_0001_0003, 64'h0, 64'h0002_0000_8000_0008, 4'h0, 4'd2},
    '{2'd1, 3'd0, 4'hF, 64'h0001_FFFF_7FFF_0005, 64'h0001_0001_0001_0003, 64'h0, 64'h0003_0000_8000_0008, 4'h0, 4'd2},
    // R1: full width and reserved code
    '{2'd0, 3'd0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 64'h0000_0001_0000_0000, 4'h0, 4'd1},
    '{2'd1, 3'd0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 64'h0000_0000_0000_0000, 4'h0, 4'd2},
    '{2'd2, 3'd0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 64'h0000_0000_FFFF_0000, 4'h0, 4'd2},
    '{2'd3, 3'd0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0, 64'h0000_0001_0000_0000, 4'h0, 4'd1},
    // R2: borrows
    '{2'd2, 3'd1, 4'hF, 64'h0, 64'h1, 64'h0, 64'h0000_0000_0000_FFFF, 4'h0, 4'd2},
    '{2'd1, 3'd1, 4'hF, 64'h0, 64'h1, 64'h0, 64'h0000_0000_FFFF_FFFF, 4'h0, 4'd2},
    '{2'd0, 3'd1, 4'hF, 64'h0, 64'h1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'h0, 4'd2},
    // R3: logic
    '{2'd2, 3'd2, 4'hF, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0, 64'hF000_F000_F000_F000, 4'h0, 4'd3},
    '{2'd0, 3'd3, 4'hF, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0, 64'hFFF0_FFF0_FFF0_FFF0, 4'h0, 4'd3},
    '{2'd1, 3'd4, 4'hF, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00, 64'h0, 64'h0FF0_0FF0_0FF0_0FF0, 4'h0, 4'd3},
    // R6: masking
    '{2'd2, 3'd0, 4'h5, 64'h0001_0001_0001_0001, 64'h0001_0001_0001_0001, 64'hAAAA_BBBB_CCCC_DDDD, 64'hAAAA_0002_CCCC_0002, 4'h0, 4'd6},
    '{2'd1, 3'd0, 4'hE, 64'h0000_0001_0000_0001, 64'h0000_0001_0000_0001, 64'h1111_2222_3333_4444, 64'h0000_0002_3333_4444, 4'h0, 4'd6},
    '{2'd0, 3'd0, 4'hE, 64'h1, 64'h1, 64'h1234_5678_9ABC_DEF0, 64'h1234_5678_9ABC_DEF0, 4'h0, 4'd6},
    // R4: compares
    '{2'd2, 3'd5, 4'hF, 64'h0005_0007_0000_1234, 64'h0005_0008_0000_4321, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 4'hA, 4'd4},
    '{2'd2, 3'd6, 4'hF, 64'h8000_0001_FFFF_7FFF, 64'h0000_0002_0000_8000, 64'h0, 64'h0, 4'hE, 4'd4},
    // R5: unused flag bits stay low
    '{2'd1, 3'd6, 4'hF, 64'h8000_0001_FFFF_7FFF, 64'h0000_0002_0000_8000, 64'h0, 64'h0, 4'h3, 4'd5},
    '{2'd0, 3'd6, 4'hF, 64'h8000_0001_FFFF_7FFF, 64'h0000_0002_0000_8000, 64'h0, 64'h0, 4'h1, 4'd5},
    '{2'd1, 3'd5, 4'h1, 64'h0000_0001_0000_0002, 64'h0000_0001_0000_0002, 64'h0, 64'h0, 4'h1, 4'd6},
    '{2'd1, 3'd5, 4'hF, 64'h0000_0000_0000_0001, 64'h0000_0000_0001_0001, 64'h0, 64'h0, 4'h2, 4'd4},
    // R10: reserved op
    '{2'd2, 3'd7, 4'hF, 64'h1, 64'h2, 64'h5555_6666_7777_8888, 64'h5555_6666_7777_8888, 4'h0, 4'd10}
  };

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [1:0]  cfg_width;
  logic        in_valid;
  logic [2:0]  in_op;
  logic [3:0]  in_mask;
  logic [63:0] in_a, in_b, in_old;
  logic        out_valid;
  logic [63:0] out_data;
  logic [3:0]  out_flags;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_lane_alu dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_width(cfg_width),
    .in_valid(in_valid), .in_op(in_op), .in_mask(in_mask),
    .in_a(in_a), .in_b(in_b), .in_old(in_old),
    .out_valid(out_valid), .out_data(out_data), .out_flags(out_flags)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_width(input logic [1:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_width = w; in_valid = 1'b0;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input logic [2:0] op, input logic [3:0] m,
                       input logic [63:0] a, input logic [63:0] b,
                       input logic [63:0] old);
    in_valid = 1'b1; in_op = op; in_mask = m; in_a = a; in_b = b; in_old = old;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_width = 2'b00; in_valid = 1'b0;
    in_op = 3'd0; in_mask = 4'h0; in_a = '0; in_b = '0; in_old = '0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "valid after reset", 64'(out_valid), 64'h0);
    chk("R9", "data after reset", out_data, 64'h0);
    chk("R9", "flags after reset", 64'(out_flags), 64'h0);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      set_width(VECS[i].w);
      issue(VECS[i].op, VECS[i].mask, VECS[i].a, VECS[i].b, VECS[i].old);
      chk(tag, "valid (R7)", 64'(out_valid), 64'h1);
      chk(tag, "data", out_data, VECS[i].exp);
      chk(tag, "flags", 64'(out_flags), 64'(VECS[i].flg));
    end

    // R7: idle cycle drops valid
    @(negedge clk);
    chk("R7", "valid when idle", 64'(out_valid), 64'h0);

    // R8: width write on the same edge as an operation
    set_width(2'b00);
    cfg_we = 1'b1; cfg_width = 2'b10;
    in_valid = 1'b1; in_op = 3'd0; in_mask = 4'hF;
    in_a = 64'h0000_0000_FFFF_FFFF; in_b = 64'h1; in_old = '0;
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R8", "same-edge op uses old width", out_data, 64'h0000_0001_0000_0000);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R8", "next op uses new width", out_data, 64'h0000_0000_FFFF_0000);

    // R9: reset mid-run clears outputs and width
    issue(3'd3, 4'hF, 64'hFF, 64'hFF00, 64'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R9", "valid cleared", 64'(out_valid), 64'h0);
    chk("R9", "data cleared", out_data, 64'h0);
    issue(3'd0, 4'hF, 64'h0000_0000_FFFF_FFFF, 64'h1, 64'h0);
    chk("R9", "width back to full", out_data, 64'h0000_0001_0000_0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule